// File: doc/BRIEF.md
# Packed byte permute unit

This block assembles a 16-byte result from a pool of 32 bytes. The pool is formed from two 128-bit source operands, with the upper source stacked above the lower one. A third 128-bit operand carries one control byte for each result lane. Each control byte names the pool byte that feeds its lane and a unary transform to apply to that byte. The transforms are pass, invert, bit reversal, and bit reversal of the inverted byte, two constants, and replication of the selected byte's top bit, either as is or inverted.

The unit sits in a vector execution pipe and takes already-read operands. By default it registers its result, which then appears one clock after the operands are sampled, together with a valid flag. A parameter removes the register and gives a purely combinational path in which the valid flag follows the input strobe. Instruction decode, register addressing and exceptions are handled outside the block.

Top module: `byteperm_unit`

## Requirements
- R1: Byte k of every 128-bit port occupies bits 8k+7:8k. For result lane k, bits 4:0 of control byte k form a pool index. Indices 0 to 15 pick byte i of `src_lo`, and indices 16 to 31 pick byte i-16 of `src_hi`.
- R2: When bits 7:5 of the control byte are 000, the lane carries the selected byte unchanged.
- R3: Code 001 gives the bitwise complement of the selected byte.
- R4: Code 010 gives the selected byte with its bit order reversed, so bit i moves to bit 7-i.
- R5: Code 011 gives the bit-reversed complement of the selected byte.
- R6: Code 100 gives 0x00 and code 101 gives 0xFF, whatever the selected byte holds.
- R7: Code 110 fills all eight bits with bit 7 of the selected byte. Code 111 fills them with the complement of that bit.
- R8: With the registered option (default), `result` and `out_valid` reflect the operands and `in_valid` sampled at the previous rising clock edge, and they do not change before that edge.
- R9: A synchronous active-high `rst` clears `out_valid` and `result` to zero at the next clock edge.
- R10: Every lane obeys only its own control byte. Different lanes may use different codes and indices in the same cycle, including the same pool byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on the inputs are valid |
| src_lo | input | 128 | Lower half of the byte pool (indices 0 to 15) |
| src_hi | input | 128 | Upper half of the byte pool (indices 16 to 31) |
| ctrl | input | 128 | One control byte per lane: index in bits 4:0, code in bits 7:5 |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Permuted and transformed bytes |

## Verification
The hardest case to reach from the ports is one lane taking a rarely used code while its neighbours take different codes and indices. Random control words seldom put one particular code on one particular lane with a chosen source byte. The stimulus therefore sweeps each code across all sixteen lanes with a deliberately rotated index, and a table vector mixes all eight codes across lanes that share pool bytes. Random operands then cover the bulk of the index and data space, and a lane-wise reference model scores every lane.

// File: rtl/bperm_pkg.sv
package bperm_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_PASS   = 3'b000,
        OP_INV    = 3'b001,
        OP_REV    = 3'b010,
        OP_REVINV = 3'b011,
        OP_ZERO   = 3'b100,
        OP_ONES   = 3'b101,
        OP_SGN    = 3'b110,
        OP_NSGN   = 3'b111
    } lane_op_e;

    function automatic logic [BYTE_W-1:0] flip_order(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/bperm_lane_sel.sv
module bperm_lane_sel #(
    parameter int unsigned POOL_BYTES = 32,
    localparam int unsigned IDX_W     = $clog2(POOL_BYTES),
    localparam int unsigned POOL_W    = POOL_BYTES * bperm_pkg::BYTE_W
) (
    input  logic [POOL_W-1:0]               pool,
    input  logic [IDX_W-1:0]                idx,
    output logic [bperm_pkg::BYTE_W-1:0]    byte_o
);
    // Byte index times eight gives the bit offset of the selected byte.
    logic [IDX_W+2:0] bit_off;

    always_comb begin
        bit_off = {idx, 3'b000};
        byte_o  = pool[bit_off +: bperm_pkg::BYTE_W];
    end

endmodule

// File: rtl/bperm_lane_op.sv
module bperm_lane_op
    import bperm_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] byte_o
);
    lane_op_e code;

    always_comb begin
        code = lane_op_e'(op);
        unique case (code)
            OP_PASS:   byte_o = byte_i;
            OP_INV:    byte_o = ~byte_i;
            OP_REV:    byte_o = flip_order(byte_i);
            OP_REVINV: byte_o = flip_order(~byte_i);
            OP_ZERO:   byte_o = '0;
            OP_ONES:   byte_o = '1;
            OP_SGN:    byte_o = {BYTE_W{byte_i[BYTE_W-1]}};
            OP_NSGN:   byte_o = {BYTE_W{~byte_i[BYTE_W-1]}};
            default:   byte_o = '0;
        endcase
    end

endmodule

// File: rtl/byteperm_unit.sv
module byteperm_unit #(
    parameter int unsigned LANES   = 16,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned DATA_W     = LANES * bperm_pkg::BYTE_W,
    localparam int unsigned POOL_BYTES = 2 * LANES,
    localparam int unsigned IDX_W      = $clog2(POOL_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_lo,
    input  logic [DATA_W-1:0] src_hi,
    input  logic [DATA_W-1:0] ctrl,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    import bperm_pkg::*;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } stage_t;

    logic [2*DATA_W-1:0] pool;
    logic [DATA_W-1:0]   lane_res;

    assign pool = {src_hi, src_lo};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] cbyte;
        logic [BYTE_W-1:0] picked;

        assign cbyte = ctrl[g*BYTE_W +: BYTE_W];

        bperm_lane_sel #(
            .POOL_BYTES (POOL_BYTES)
        ) u_sel (
            .pool   (pool),
            .idx    (cbyte[IDX_W-1:0]),
            .byte_o (picked)
        );

        bperm_lane_op u_op (
            .op     (cbyte[BYTE_W-1 -: OP_W]),
            .byte_i (picked),
            .byte_o (lane_res[g*BYTE_W +: BYTE_W])
        );
    end

    if (REG_OUT) begin : g_reg
        stage_t st_d, st_q;

        always_comb begin
            st_d.vld  = in_valid;
            st_d.data = lane_res;
            if (rst) begin
                st_d = '0;
            end
        end

        always_ff @(posedge clk) begin
            st_q <= st_d;
        end

        assign out_valid = st_q.vld;
        assign result    = st_q.data;
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst;
        assign out_valid      = in_valid;
        assign result         = lane_res;
    end

endmodule

// File: rtl/bperm_chk.sv
module bperm_chk #(
    parameter int unsigned LANES   = 16,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned DATA_W = LANES * 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] src_lo,
    input logic [DATA_W-1:0] src_hi,
    input logic [DATA_W-1:0] ctrl,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    if (REG_OUT) begin : g_reg_chk
        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);  // R8
        AST_NO_PHANTOM_VALID: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);  // R8
        AST_RESET_CLEARS: assert property (@(posedge clk)
            rst |=> (!out_valid && result == '0));  // R9
        AST_PASS_LANE0: assert property (@(posedge clk) disable iff (rst)
            (ctrl[7:0] == 8'h00) |=> (result[7:0] == $past(src_lo[7:0])));  // R2
        AST_HI_LANE0: assert property (@(posedge clk) disable iff (rst)
            (ctrl[7:0] == 8'h10) |=> (result[7:0] == $past(src_hi[7:0])));  // R1

        for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
            AST_CONST_ZERO: assert property (@(posedge clk) disable iff (rst)
                (ctrl[8*k+7 -: 3] == 3'b100) |=> (result[8*k +: 8] == 8'h00));  // R6
            AST_CONST_ONES: assert property (@(posedge clk) disable iff (rst)
                (ctrl[8*k+7 -: 3] == 3'b101) |=> (result[8*k +: 8] == 8'hFF));  // R6
            AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
                (ctrl[8*k+7 -: 2] == 2'b11) |=>
                ($countones(result[8*k +: 8]) == 0 || $countones(result[8*k +: 8]) == 8));  // R7
        end
    end else begin : g_comb_chk
        logic unused_in;
        assign unused_in = clk ^ rst ^ ^src_lo ^ ^src_hi ^ ^ctrl ^ ^result;
        always_comb begin
            AST_COMB_VALID: assert (out_valid == in_valid);  // R8
        end
    end

endmodule

bind byteperm_unit bperm_chk #(
    .LANES   (LANES),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_lo    (src_lo),
    .src_hi    (src_hi),
    .ctrl      (ctrl),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/byteperm_unit_bench.sv
module byteperm_unit_bench;

    localparam int NTBL = 4;
    localparam logic [127:0] TBL_LO [NTBL] = '{
        128'h0F0E0D0C0B0A09080706050403020100,
        128'h8123456789ABCDEF0123456789ABCDEF,
        128'hF0E1D2C3B4A5968778695A4B3C2D1E0F,
        128'h00112233445566778899AABBCCDDEEFF
    };
    localparam logic [127:0] TBL_HI [NTBL] = '{
        128'h1F1E1D1C1B1A19181716151413121110,
        128'hFEDCBA9876543210FEDCBA9876543210,
        128'h0102040810204080FFFEFDFBF7EFDFBF,
        128'h80808080010101017F7F7F7FFEFEFEFE
    };
    localparam logic [127:0] TBL_CTRL [NTBL] = '{
        128'h0F0E0D0C0B0A09080706050403020100,
        128'h101112131415161718191A1B1C1D1E1F,
        128'hE5C5A5856545250504E4C4A484644424,
        128'h3F5F1F7F9FBFDFFF00204060A0C0E010
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src_lo = '0;
    logic [127:0] src_hi = '0;
    logic [127:0] ctrl = '0;
    logic         out_valid;
    logic [127:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    byteperm_unit u_byteperm_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .src_lo    (src_lo),
        .src_hi    (src_hi),
        .ctrl      (ctrl),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [7:0] model_lane(input logic [127:0] lo, input logic [127:0] hi,
                                              input logic [7:0] c);
        logic [7:0] s;
        int idx;
        idx = int'(c[4:0]);
        s = (idx < 16) ? lo[8*idx +: 8] : hi[8*(idx-16) +: 8];
        case (c[7:5])
            3'd0: return s;
            3'd1: return ~s;
            3'd2: return {s[0], s[1], s[2], s[3], s[4], s[5], s[6], s[7]};
            3'd3: return ~{s[0], s[1], s[2], s[3], s[4], s[5], s[6], s[7]};
            3'd4: return 8'h00;
            3'd5: return 8'hFF;
            3'd6: return s[7] ? 8'hFF : 8'h00;
            default: return s[7] ? 8'h00 : 8'hFF;
        endcase
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4, 3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, score at the next falling edge (one register).
    task automatic apply(input logic [127:0] lo, input logic [127:0] hi,
                         input logic [127:0] c, input string ctx);
        @(negedge clk);
        src_lo = lo; src_hi = hi; ctrl = c; in_valid = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b1, "R8 valid", {127'b0, out_valid}, 128'd1);
        for (int k = 0; k < 16; k++) begin
            logic [7:0] e;
            e = model_lane(lo, hi, c[8*k +: 8]);
            check(result[8*k +: 8] === e, {ctx, " ", op_tag(c[8*k+5 +: 3]), " R1 R10"},
                  {120'b0, result[8*k +: 8]}, {120'b0, e});
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] lo, hi, c, e_first;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid === 1'b0, "R9 reset valid", {127'b0, out_valid}, 128'd0);
        check(result === '0, "R9 reset result", result, 128'd0);
        rst = 1'b0;

        // Table vectors
        for (int t = 0; t < NTBL; t++) begin
            apply(TBL_LO[t], TBL_HI[t], TBL_CTRL[t], "table");
        end

        // Every code on every lane, index rotated per lane
        lo = 128'h7F80C3A5_01FE5A96_E1873C0F_FF0055AA;
        hi = 128'h9B2D46F0_8E71A0C5_3355CCAA_10204080;
        for (int op = 0; op < 8; op++) begin
            c = '0;
            for (int k = 0; k < 16; k++) begin
                c[8*k +: 8] = {op[2:0], 5'((k * 7 + op * 3) % 32)};
            end
            apply(lo, hi, c, "sweep");
        end

        // Random operands
        for (int r = 0; r < 200; r++) begin
            apply({$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom}, "random");
        end

        // R8: output holds until the next edge after new operands arrive
        c = TBL_CTRL[1];
        apply(TBL_LO[1], TBL_HI[1], c, "hold");
        e_first = result;
        @(negedge clk);
        src_lo = ~TBL_LO[1]; src_hi = ~TBL_HI[1];
        #1;
        check(result === e_first, "R8 no early change", result, e_first);
        @(negedge clk);
        check(result === ~e_first, "R8 next edge", result, ~e_first);

        // R8: idle strobe gives no valid
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R8 idle", {127'b0, out_valid}, 128'd0);

        // R6: constants ignore the selected byte, both halves of pool
        apply('1, '0, {16{8'h80}}, "const0");
        apply('0, '1, {16{8'hB0}}, "const1");

        // R9: reset mid-stream
        @(negedge clk);
        in_valid = 1'b1; ctrl = {16{8'hA0}};
        rst = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R9 mid reset valid", {127'b0, out_valid}, 128'd0);
        check(result === '0, "R9 mid reset result", result, 128'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule